// File: doc/BRIEF.md
# Packet channel reorder buffer

The block takes in a packetised stream of channel samples and writes each packet into one page of a two-page memory. When a packet's last sample has been written, that page becomes readable. An external read master then fetches the channels it wants, in any order and with repeats allowed, through a memory-mapped select port. That port has an address, a read strobe and a waitrequest. The words that are read leave the block as a new output packet. Each output packet carries the framing and the header fields of the input packet it came from.

While one page is being read, the next input packet fills the other page. The total channel count and the selected channel count can change between packets. Both counts are sampled at the start of each input packet and are stored with its page, so the read side and the output always use the counts that belong to the packet being drained. A busy flag tells the surrounding logic when it is safe to change the counts.

Top module: `chan_reorder_buf`

## Requirements
- R1: While reset is held and in the cycle after it, `sel_waitreq` is 1, `out_valid` is 0 and `busy` is 0.
- R2: `sel_waitreq` stays 1 until an input packet has been completely written. It is 0 from the cycle after the clock edge that accepts the input eop, while no read page is already full.
- R3: A read accepted on cycle c (`sel_rd`=1 and `sel_waitreq`=0) returns the word stored at `sel_addr` on `sel_rdata` and on the output data, with `out_valid`=1, in cycle c+2.
- R4: The first accepted read of a page produces `out_sop`, and read number N produces `out_eop`, where N is the selected count captured for that page (from 1 to MAX_CH). After that read the page is released, and `sel_waitreq` returns to 1 unless the other page is already full.
- R5: Input cycles with `in_valid`=0 write nothing. Word k of a packet (counting valid cycles from the sop as k=0) is stored at address k.
- R6: `cfg_nof_in` and `cfg_nof_sel` are sampled on the input sop cycle only. They appear on `out_nof_in` and `out_nof_sel` on every output cycle of that packet. Changes made after the sop have no effect.
- R7: `out_bsn`, `out_chan` and `out_err` equal the values presented with the matching input sop, on every output cycle of the packet. `out_sync` equals the input sync on the `out_sop` cycle and is 0 on the other output cycles.
- R8: With COMPLEX=0 the stored word is `in_data`, it is returned on `out_data`, and `out_re`/`out_im` are 0. With COMPLEX=1 the stored word is {`in_im`,`in_re`}, it is returned on `out_im`/`out_re`, and `out_data` is 0. `sel_rdata` always carries the stored word.
- R9: `busy` is 1 from the cycle after an input sop is accepted until the cycle after the `out_eop` of the last outstanding packet, and then it is 0.
- R10: A second packet may be written while the first page is being read. Its reads are served, with correct data, once the first page has been released.
- R11: A read strobe given while `sel_waitreq`=1 is ignored. It produces no output and does not advance the read count of the next page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input sample valid |
| in_sop | input | 1 | First sample of an input packet |
| in_eop | input | 1 | Last sample of an input packet |
| in_sync | input | 1 | Sync flag, taken at sop |
| in_bsn | input | 16 | Block sequence number, taken at sop |
| in_chan | input | 8 | Channel field, taken at sop |
| in_err | input | 4 | Error field, taken at sop |
| in_data | input | 2*DW | Real-mode sample |
| in_re | input | DW | Complex-mode real part |
| in_im | input | DW | Complex-mode imaginary part |
| cfg_nof_in | input | CNT_W | Channels per input packet |
| cfg_nof_sel | input | CNT_W | Channels read per output packet |
| busy | output | 1 | A packet is in flight |
| sel_addr | input | AW | Read address |
| sel_rd | input | 1 | Read strobe |
| sel_rdata | output | 2*DW | Read data, two cycles after the address |
| sel_waitreq | output | 1 | High while no page is readable |
| out_valid | output | 1 | Output sample valid |
| out_sop | output | 1 | First sample of an output packet |
| out_eop | output | 1 | Last sample of an output packet |
| out_sync | output | 1 | Sync of the source packet, on sop |
| out_bsn | output | 16 | Block sequence number of the source packet |
| out_chan | output | 8 | Channel field of the source packet |
| out_err | output | 4 | Error field of the source packet |
| out_data | output | 2*DW | Real-mode output sample |
| out_re | output | DW | Complex-mode real part |
| out_im | output | DW | Complex-mode imaginary part |
| out_nof_in | output | CNT_W | Captured input channel count |
| out_nof_sel | output | CNT_W | Captured selected channel count |

## Verification
A wrong page pointer or a wrong full flag shows up on `sel_waitreq` in the cycle after an input eop or after the last read, and two cycles later as data taken from the wrong packet. A read count that is off by one moves `out_eop` or `out_sop`, and that is seen within the packet it corrupts. A count or header captured at the wrong moment gives wrong `out_nof_*` or header values, because the bench changes those inputs after every sop. A busy counter that drifts is caught in the cycle after the final output eop.

// File: rtl/crb_pkg.sv
package crb_pkg;
    localparam int BSN_W  = 16;
    localparam int CHAN_W = 8;
    localparam int ERR_W  = 4;

    typedef struct packed {
        logic              sync;
        logic [BSN_W-1:0]  bsn;
        logic [CHAN_W-1:0] chan;
        logic [ERR_W-1:0]  err;
    } pkt_meta_t;

    // effective number of reads per page: at least one, at most the page size
    function automatic int sel_len(input int req, input int max_ch);
        if (req <= 0)
            return 1;
        if (req > max_ch)
            return max_ch;
        return req;
    endfunction
endpackage

// File: rtl/crb_page_ctrl.sv
module crb_page_ctrl (
    input  logic clk,
    input  logic rst,
    input  logic wr_done,
    input  logic rd_done,
    output logic wr_page,
    output logic rd_page,
    output logic rd_ready
);
    logic [1:0] full;

    always_ff @(posedge clk) begin
        if (rst) begin
            full    <= '0;
            wr_page <= 1'b0;
            rd_page <= 1'b0;
        end else begin
            if (rd_done) begin
                full[rd_page] <= 1'b0;
                rd_page       <= ~rd_page;
            end
            if (wr_done) begin
                full[wr_page] <= 1'b1;
                wr_page       <= ~wr_page;
            end
        end
    end

    assign rd_ready = full[rd_page];

    // R10: a page is never refilled while it still waits to be read
    p_no_overrun_r10: assert property (@(posedge clk) disable iff (rst)
        wr_done |-> !full[wr_page]);
endmodule

// File: rtl/crb_wr_ctrl.sv
module crb_wr_ctrl #(
    parameter int MAX_CH = 16,
    localparam int AW    = $clog2(MAX_CH),
    localparam int CNT_W = $clog2(MAX_CH + 1)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           in_valid,
    input  logic           in_sop,
    input  logic           in_eop,
    output logic           wr_en,
    output logic [AW-1:0]  wr_addr,
    output logic           meta_we,
    output logic           wr_done
);
    logic [CNT_W-1:0] wr_cnt;
    logic [CNT_W-1:0] addr_now;

    assign addr_now = in_sop ? '0 : wr_cnt;
    assign wr_en    = in_valid && (int'(addr_now) < MAX_CH);
    assign wr_addr  = addr_now[AW-1:0];
    assign meta_we  = in_valid && in_sop;
    assign wr_done  = in_valid && in_eop;

    always_ff @(posedge clk) begin
        if (rst)
            wr_cnt <= '0;
        else if (in_valid && int'(addr_now) < MAX_CH)
            wr_cnt <= addr_now + 1'b1;
    end

    // R5: the write address only moves on valid input cycles
    p_addr_hold_r5: assert property (@(posedge clk) disable iff (rst)
        !$past(in_valid) && !$past(rst) |-> $stable(wr_cnt));
endmodule

// File: rtl/crb_page_mem.sv
module crb_page_mem import crb_pkg::*; #(
    parameter int W2     = 16,
    parameter int MAX_CH = 16,
    localparam int AW    = $clog2(MAX_CH),
    localparam int CNT_W = $clog2(MAX_CH + 1)
) (
    input  logic             clk,
    input  logic             we,
    input  logic             wpage,
    input  logic [AW-1:0]    waddr,
    input  logic [W2-1:0]    wdata,
    input  logic             mwe,
    input  pkt_meta_t        wmeta,
    input  logic [CNT_W-1:0] wnin,
    input  logic [CNT_W-1:0] wnsel,
    input  logic             re,
    input  logic             rpage,
    input  logic [AW-1:0]    raddr,
    output logic [W2-1:0]    rdata,
    output pkt_meta_t        rmeta,
    output logic [CNT_W-1:0] rnin,
    output logic [CNT_W-1:0] rnsel
);
    localparam int DEPTH = 2 * MAX_CH;

    logic [W2-1:0]    words [DEPTH];
    pkt_meta_t        metas [2];
    logic [CNT_W-1:0] nins  [2];
    logic [CNT_W-1:0] nsels [2];

    always_ff @(posedge clk) begin
        if (we)
            words[int'(wpage) * MAX_CH + int'(waddr)] <= wdata;
        if (mwe) begin
            metas[wpage] <= wmeta;
            nins[wpage]  <= wnin;
            nsels[wpage] <= wnsel;
        end
        if (re)
            rdata <= (int'(raddr) < MAX_CH) ? words[int'(rpage) * MAX_CH + int'(raddr)] : '0;
    end

    assign rmeta = metas[rpage];
    assign rnin  = nins[rpage];
    assign rnsel = nsels[rpage];
endmodule

// File: rtl/crb_rd_pipe.sv
module crb_rd_pipe import crb_pkg::*; #(
    parameter int W2     = 16,
    parameter int MAX_CH = 16,
    localparam int CNT_W = $clog2(MAX_CH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             acc,
    input  pkt_meta_t        pmeta,
    input  logic [CNT_W-1:0] pnin,
    input  logic [CNT_W-1:0] pnsel,
    input  logic [W2-1:0]    rdata,
    output logic             rd_done,
    output logic             out_valid,
    output logic             out_sop,
    output logic             out_eop,
    output pkt_meta_t        out_meta,
    output logic [W2-1:0]    out_word,
    output logic [CNT_W-1:0] out_nin,
    output logic [CNT_W-1:0] out_nsel
);
    typedef struct packed {
        logic             vld;
        logic             sop;
        logic             eop;
        pkt_meta_t        meta;
        logic [CNT_W-1:0] nin;
        logic [CNT_W-1:0] nsel;
    } rd_stage_t;

    logic [CNT_W-1:0] rd_cnt;
    logic             last;
    rd_stage_t        st1;

    assign last    = int'(rd_cnt) == sel_len(int'(pnsel), MAX_CH) - 1;
    assign rd_done = acc && last;

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_cnt    <= '0;
            st1       <= '0;
            out_valid <= 1'b0;
            out_sop   <= 1'b0;
            out_eop   <= 1'b0;
            out_meta  <= '0;
            out_word  <= '0;
            out_nin   <= '0;
            out_nsel  <= '0;
        end else begin
            if (acc)
                rd_cnt <= last ? '0 : rd_cnt + 1'b1;
            st1.vld  <= acc;
            st1.sop  <= acc && rd_cnt == '0;
            st1.eop  <= acc && last;
            st1.meta <= pmeta;
            st1.nin  <= pnin;
            st1.nsel <= pnsel;
            out_valid     <= st1.vld;
            out_sop       <= st1.sop;
            out_eop       <= st1.eop;
            out_meta      <= st1.meta;
            out_meta.sync <= st1.meta.sync && st1.sop;
            out_word      <= rdata;
            out_nin       <= st1.nin;
            out_nsel      <= st1.nsel;
        end
    end

    // checker state: outputs seen so far in the current output packet
    logic [CNT_W-1:0] ocnt;
    always_ff @(posedge clk) begin
        if (rst)
            ocnt <= '0;
        else if (out_valid)
            ocnt <= out_eop ? '0 : ocnt + 1'b1;
    end

    // R4: sop starts a fresh count, eop lands on the captured selection length
    p_sop_first_r4: assert property (@(posedge clk) disable iff (rst)
        out_valid && out_sop |-> ocnt == '0);
    p_eop_count_r4: assert property (@(posedge clk) disable iff (rst)
        out_valid && out_eop |-> int'(ocnt) + 1 == sel_len(int'(out_nsel), MAX_CH));
    // R7: sync never appears away from the output sop
    p_sync_at_sop_r7: assert property (@(posedge clk) disable iff (rst)
        out_meta.sync |-> out_sop && out_valid);
endmodule

// File: rtl/chan_reorder_buf.sv
module chan_reorder_buf import crb_pkg::*; #(
    parameter int DW      = 8,
    parameter int MAX_CH  = 16,
    parameter bit COMPLEX = 1'b0,
    localparam int W2     = 2 * DW,
    localparam int AW     = $clog2(MAX_CH),
    localparam int CNT_W  = $clog2(MAX_CH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic              in_sop,
    input  logic              in_eop,
    input  logic              in_sync,
    input  logic [BSN_W-1:0]  in_bsn,
    input  logic [CHAN_W-1:0] in_chan,
    input  logic [ERR_W-1:0]  in_err,
    input  logic [W2-1:0]     in_data,
    input  logic [DW-1:0]     in_re,
    input  logic [DW-1:0]     in_im,
    input  logic [CNT_W-1:0]  cfg_nof_in,
    input  logic [CNT_W-1:0]  cfg_nof_sel,
    output logic              busy,
    input  logic [AW-1:0]     sel_addr,
    input  logic              sel_rd,
    output logic [W2-1:0]     sel_rdata,
    output logic              sel_waitreq,
    output logic              out_valid,
    output logic              out_sop,
    output logic              out_eop,
    output logic              out_sync,
    output logic [BSN_W-1:0]  out_bsn,
    output logic [CHAN_W-1:0] out_chan,
    output logic [ERR_W-1:0]  out_err,
    output logic [W2-1:0]     out_data,
    output logic [DW-1:0]     out_re,
    output logic [DW-1:0]     out_im,
    output logic [CNT_W-1:0]  out_nof_in,
    output logic [CNT_W-1:0]  out_nof_sel
);
    logic             wr_en, meta_we, wr_done, rd_done;
    logic [AW-1:0]    wr_addr;
    logic             wr_page, rd_page, rd_ready, acc;
    logic [W2-1:0]    in_word, mem_rdata, out_word;
    pkt_meta_t        in_meta, page_meta, o_meta;
    logic [CNT_W-1:0] page_nin, page_nsel;
    logic [1:0]       pend;

    assign in_word     = COMPLEX ? {in_im, in_re} : in_data;
    assign in_meta     = '{sync: in_sync, bsn: in_bsn, chan: in_chan, err: in_err};
    assign sel_waitreq = !rd_ready;
    assign acc         = sel_rd && rd_ready;

    crb_wr_ctrl #(.MAX_CH(MAX_CH)) i_wr (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_sop(in_sop), .in_eop(in_eop),
        .wr_en(wr_en), .wr_addr(wr_addr), .meta_we(meta_we), .wr_done(wr_done));

    crb_page_ctrl i_pages (
        .clk(clk), .rst(rst), .wr_done(wr_done), .rd_done(rd_done),
        .wr_page(wr_page), .rd_page(rd_page), .rd_ready(rd_ready));

    crb_page_mem #(.W2(W2), .MAX_CH(MAX_CH)) i_mem (
        .clk(clk), .we(wr_en), .wpage(wr_page), .waddr(wr_addr), .wdata(in_word),
        .mwe(meta_we), .wmeta(in_meta), .wnin(cfg_nof_in), .wnsel(cfg_nof_sel),
        .re(acc), .rpage(rd_page), .raddr(sel_addr), .rdata(mem_rdata),
        .rmeta(page_meta), .rnin(page_nin), .rnsel(page_nsel));

    crb_rd_pipe #(.W2(W2), .MAX_CH(MAX_CH)) i_rd (
        .clk(clk), .rst(rst), .acc(acc), .pmeta(page_meta), .pnin(page_nin),
        .pnsel(page_nsel), .rdata(mem_rdata), .rd_done(rd_done),
        .out_valid(out_valid), .out_sop(out_sop), .out_eop(out_eop),
        .out_meta(o_meta), .out_word(out_word), .out_nin(out_nof_in),
        .out_nsel(out_nof_sel));

    // packets accepted at the input but not yet fully output
    always_ff @(posedge clk) begin
        if (rst)
            pend <= '0;
        else
            pend <= pend + {1'b0, in_valid && in_sop} - {1'b0, out_valid && out_eop};
    end
    assign busy = pend != '0;

    assign sel_rdata = out_word;
    assign out_data  = COMPLEX ? '0 : out_word;
    assign out_re    = COMPLEX ? out_word[DW-1:0] : '0;
    assign out_im    = COMPLEX ? out_word[W2-1:DW] : '0;
    assign out_sync  = o_meta.sync;
    assign out_bsn   = o_meta.bsn;
    assign out_chan  = o_meta.chan;
    assign out_err   = o_meta.err;

    // R1: the cycle after reset offers nothing to read
    p_wait_reset_r1: assert property (@(posedge clk)
        $past(rst) |-> sel_waitreq && !out_valid && !busy);
    // R2: the read side opens only after an input eop or a page hand-over
    p_wait_fall_r2: assert property (@(posedge clk) disable iff (rst)
        $fell(sel_waitreq) |-> $past(in_valid && in_eop) || $past(rd_done));
    // R3/R11: every output word comes from a read accepted two cycles before
    p_rd_latency_r3: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(sel_rd && !sel_waitreq, 2));
    // R9: an output sample always belongs to a packet counted as in flight
    p_busy_cover_r9: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> busy);
endmodule

// File: tb/test_chan_reorder_buf.sv
`timescale 1ns/1ps
module test_chan_reorder_buf;
    import crb_pkg::*;
    localparam int DW = 8, MAX_CH = 16, W2 = 16, AW = 4, CNT_W = 5;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic in_valid = 0, in_sop = 0, in_eop = 0, in_sync = 0, sel_rd = 0;
    logic [BSN_W-1:0] in_bsn = '0;
    logic [CHAN_W-1:0] in_chan = '0;
    logic [ERR_W-1:0] in_err = '0;
    logic [W2-1:0] in_data = '0;
    logic [CNT_W-1:0] cfg_nof_in = '0, cfg_nof_sel = '0;
    logic [AW-1:0] sel_addr = '0;

    logic busy, sel_waitreq, out_valid, out_sop, out_eop, out_sync;
    logic [W2-1:0] sel_rdata, out_data, c_rdata, c_data;
    logic [BSN_W-1:0] out_bsn, c_bsn;
    logic [CHAN_W-1:0] out_chan, c_chan;
    logic [ERR_W-1:0] out_err, c_err;
    logic [DW-1:0] out_re, out_im, c_re, c_im;
    logic [CNT_W-1:0] out_nof_in, out_nof_sel, c_nin, c_nsel;
    logic c_busy, c_wait, c_valid, c_sop, c_eop, c_sync;

    chan_reorder_buf #(.DW(DW), .MAX_CH(MAX_CH), .COMPLEX(1'b0)) i_chan_reorder_buf (
        .clk, .rst, .in_valid, .in_sop, .in_eop, .in_sync, .in_bsn, .in_chan, .in_err,
        .in_data, .in_re(in_data[DW-1:0]), .in_im(in_data[W2-1:DW]), .cfg_nof_in, .cfg_nof_sel,
        .busy, .sel_addr, .sel_rd, .sel_rdata, .sel_waitreq, .out_valid, .out_sop,
        .out_eop, .out_sync, .out_bsn, .out_chan, .out_err, .out_data, .out_re, .out_im,
        .out_nof_in, .out_nof_sel);

    chan_reorder_buf #(.DW(DW), .MAX_CH(MAX_CH), .COMPLEX(1'b1)) i_chan_reorder_buf_cx (
        .clk, .rst, .in_valid, .in_sop, .in_eop, .in_sync, .in_bsn, .in_chan, .in_err,
        .in_data(~in_data), .in_re(in_data[DW-1:0]), .in_im(in_data[W2-1:DW]),
        .cfg_nof_in, .cfg_nof_sel, .busy(c_busy), .sel_addr, .sel_rd, .sel_rdata(c_rdata),
        .sel_waitreq(c_wait), .out_valid(c_valid), .out_sop(c_sop), .out_eop(c_eop),
        .out_sync(c_sync), .out_bsn(c_bsn), .out_chan(c_chan), .out_err(c_err),
        .out_data(c_data), .out_re(c_re), .out_im(c_im), .out_nof_in(c_nin),
        .out_nof_sel(c_nsel));

    int n_chk = 0, n_bad = 0;
    logic [W2-1:0] pw [2][MAX_CH];
    int pn [2], ps [2];
    pkt_meta_t pm [2];

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%0h exp=%0h t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic gen_pkt(input int slot, input int n, input int s);
        pn[slot] = n;
        ps[slot] = s;
        for (int i = 0; i < MAX_CH; i++) pw[slot][i] = W2'($urandom);
        pm[slot] = pkt_meta_t'($urandom);
    endtask

    task automatic send_pkt(input int slot, input int gapmax, input bit chk_wait);
        for (int i = 0; i < pn[slot]; i++) begin
            int gaps = (gapmax > 0) ? int'($urandom % (gapmax + 1)) : 0;
            repeat (gaps) begin
                in_valid = 0; in_sop = 0; in_eop = 0;
                in_data = W2'($urandom);          // R5: garbage on invalid cycles
                step();
            end
            in_valid = 1;
            in_sop = (i == 0);
            in_eop = (i == pn[slot] - 1);
            in_data = pw[slot][i];
            if (i == 0) begin
                {in_sync, in_bsn, in_chan, in_err} = pm[slot];
                cfg_nof_in = CNT_W'(pn[slot]);
                cfg_nof_sel = CNT_W'(ps[slot]);
            end else begin
                {in_sync, in_bsn, in_chan, in_err} = pkt_meta_t'($urandom);  // R6/R7: ignored
                cfg_nof_in = CNT_W'($urandom);
                cfg_nof_sel = CNT_W'($urandom);
            end
            if (chk_wait && in_eop) chk("R2 wait before eop", sel_waitreq, 1);
            step();
            if (i == 0) chk("R9 busy after sop", busy, 1);
        end
        in_valid = 0; in_sop = 0; in_eop = 0;
        cfg_nof_in = CNT_W'($urandom);
        cfg_nof_sel = CNT_W'($urandom);
        chk("R2 wait low after eop", sel_waitreq, 0);
    endtask

    task automatic read_pkt(input int slot);
        int nsel = ps[slot];
        int aq [MAX_CH];
        while (sel_waitreq) step();
        for (int i = 0; i < nsel; i++) aq[i] = int'($urandom % pn[slot]);
        for (int j = 0; j < nsel + 2; j++) begin
            if (j < nsel) begin
                sel_rd = 1;
                sel_addr = AW'(aq[j]);
            end else begin
                sel_rd = 0;
                sel_addr = AW'($urandom);
            end
            if (j >= 2) begin
                int k = j - 2;
                logic [W2-1:0] w = pw[slot][aq[k]];
                chk("R3 valid", out_valid, 1);
                chk("R3 rdata", sel_rdata, w);
                chk("R8 real data", out_data, w);
                chk("R8 real re/im zero", {out_im, out_re}, 0);
                chk("R8 complex re/im", {c_im, c_re}, w);
                chk("R8 complex data zero", c_data, 0);
                chk("R4 sop", out_sop, k == 0);
                chk("R4 eop", out_eop, k == nsel - 1);
                chk("R7 sync", out_sync, (k == 0) ? pm[slot].sync : 1'b0);
                chk("R7 bsn/chan/err", {out_bsn, out_chan, out_err},
                    {pm[slot].bsn, pm[slot].chan, pm[slot].err});
                chk("R6 counts", {out_nof_in, out_nof_sel}, {CNT_W'(pn[slot]), CNT_W'(nsel)});
            end
            step();
        end
        chk("R4 no extra output", out_valid, 0);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        step(); step();
        chk("R1 wait in reset", sel_waitreq, 1);
        chk("R1 valid in reset", out_valid, 0);
        chk("R1 busy in reset", busy, 0);
        repeat (3) step();
        rst = 0;
        step();
        chk("R1 wait after reset", sel_waitreq, 1);
        chk("R1 busy after reset", busy, 0);

        // R11: reads while nothing is readable are dropped
        sel_rd = 1; sel_addr = 0;
        repeat (3) step();
        sel_rd = 0;
        chk("R11 no output", out_valid, 0);
        step();
        chk("R11 no output late", out_valid, 0);
        step();
        chk("R11 no output end", out_valid, 0);

        // directed: one-channel packet with sop and eop together
        gen_pkt(0, 1, 1);
        send_pkt(0, 0, 1);
        read_pkt(0);
        chk("R9 busy clear", busy, 0);
        chk("R4 page released", sel_waitreq, 1);

        // directed: full page, all channels selected
        gen_pkt(0, MAX_CH, MAX_CH);
        send_pkt(0, 2, 1);
        read_pkt(0);
        chk("R9 busy clear full", busy, 0);

        // random packets with input gaps
        for (int p = 0; p < 20; p++) begin
            int n = 1 + int'($urandom % MAX_CH);
            gen_pkt(0, n, 1 + int'($urandom % n));
            send_pkt(0, 3, 1);
            read_pkt(0);
            chk("R9 busy clear random", busy, 0);
        end

        // R10: fill the second page while the first drains
        gen_pkt(0, 12, 10);
        gen_pkt(1, 9, 7);
        send_pkt(0, 1, 1);
        fork
            send_pkt(1, 1, 0);
            read_pkt(0);
        join
        chk("R10 busy while second pending", busy, 1);
        read_pkt(1);
        chk("R10 busy clear", busy, 0);
        chk("R10 wait high at end", sel_waitreq, 1);

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule